// File: doc/BRIEF.md
# TFT Column Driver Row Model

This block models the column side of a bare TFT panel that has no timing controller of its own. It lets a timing-controller design be checked in simulation against something that behaves like the real panel input. A start strobe arms a single write token. Each shift strobe then drops the present pixel into the column that holds the token and moves the token one column on. A separate latch strobe copies the whole captured row to the output register in one step. With that row it also stores the polarity level, and it raises a one-cycle row-valid flag.

All strobes are synchronous enables that are sampled on the rising edge of `clk`. The token sequencer is a two-state machine. In `TK_IDLE` no token exists. In `TK_WALK` a token sits on a column. The transitions are:

- `TK_IDLE`→`TK_WALK` on a start strobe.
- `TK_WALK`→`TK_WALK` on a start strobe, which restarts the token, or on a shift strobe before the last column.
- `TK_WALK`→`TK_IDLE` on the shift strobe that writes the last column.

Each pixel is 18 bits: red in bits 17:12, green in bits 11:6, blue in bits 5:0. Column c of the output row sits at `row_data[c*18 +: 18]`.

Top module: `sd_source_row`

## Requirements
- R1: While `rst` is high at a clock edge, the token is cleared, every captured column becomes 0, and `row_data`, `row_pol` and `row_valid` become 0.
- R2: A cycle with `start` high arms the token at the first column. No column is written in that cycle, even if `shift` is also high.
- R3: Each cycle with `shift` high, no `start`, and a live token writes the pixel into the token's column and then advances the token. When `dir_rl`=0 the columns fill from 0 upward. When `dir_rl`=1 they fill from NCOL-1 downward.
- R4: The token expires after the shift that writes the NCOL-th column. Later shifts write nothing until the next `start`.
- R5: A shift with no live token has no effect. Columns that are not written keep their previous contents across rows.
- R6: A `start` that arrives while the token is walking puts the token back at the first column.
- R7: When `inv_en` is 1 in the write cycle, the stored value is the bitwise complement of all 18 pixel bits. When it is 0, the pixel is stored unchanged.
- R8: A cycle with `latch` high makes `row_data` equal, from the next cycle on, to the captured row as it stood before that cycle's write. In every other cycle `row_data` holds its value.
- R9: `row_pol` takes the value of `pol_in` from the latch cycle and holds it between latches. `row_valid` is high exactly in the cycle after each latch cycle.
- R10: The direction is sampled only on `start`. Changing `dir_rl` while the token is walking has no effect on the remaining columns of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Row start strobe, arms the token |
| shift | input | 1 | Column shift strobe |
| pixel | input | 18 | Pixel {R[5:0],G[5:0],B[5:0]} |
| inv_en | input | 1 | Store the pixel complemented |
| dir_rl | input | 1 | 0: fill from column 0; 1: fill from column NCOL-1 |
| latch | input | 1 | Row transfer strobe |
| pol_in | input | 1 | Polarity level captured on latch |
| row_data | output | NCOL*18 | Latched row, column c at [c*18 +: 18] |
| row_pol | output | 1 | Polarity stored with the latched row |
| row_valid | output | 1 | One-cycle flag after each latch |

## Verification
The hardest conditions to reach are collisions of strobes in a single cycle. These are start together with shift, latch together with the write of a column, and a start that lands part way through a row. The internal token position is visible only through which columns show up after a latch. The stimulus therefore writes rows that are deliberately incomplete, restarted, or over-shifted, and follows each with a latch. A later partial row in the opposite direction then shows that the untouched columns kept their old contents.

// File: rtl/sd_pkg.sv
package sd_pkg;
    localparam int CH_W  = 6;
    localparam int PIX_W = 3 * CH_W;

    typedef enum logic [0:0] {
        TK_IDLE = 1'b0,
        TK_WALK = 1'b1
    } tk_state_e;

    function automatic logic [PIX_W-1:0] pix_fix(input logic [PIX_W-1:0] px,
                                                 input logic inv);
        return inv ? ~px : px;
    endfunction
endpackage

// File: rtl/sd_token_seq.sv
module sd_token_seq
    import sd_pkg::*;
#(
    parameter int NCOL = 8,
    localparam int CIDX_W = (NCOL > 1) ? $clog2(NCOL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              shift,
    input  logic              dir_rl,
    output logic              tok_live,
    output logic              wr_en,
    output logic [CIDX_W-1:0] wr_col
);
    localparam logic [CIDX_W-1:0] LAST = CIDX_W'(NCOL - 1);

    tk_state_e         state_q, state_d;
    logic [CIDX_W-1:0] idx_q, idx_d;
    logic              dir_q, dir_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TK_IDLE;
            idx_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            dir_q   <= dir_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        dir_d   = dir_q;
        wr_en   = 1'b0;
        if (start) begin
            state_d = TK_WALK;
            idx_d   = '0;
            dir_d   = dir_rl;
        end else begin
            unique case (state_q)
                TK_IDLE: begin
                    idx_d = '0;
                end
                TK_WALK: begin
                    if (shift) begin
                        wr_en = 1'b1;
                        if (idx_q == LAST) begin
                            state_d = TK_IDLE;
                            idx_d   = '0;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end
                default: state_d = TK_IDLE;
            endcase
        end
    end

    assign tok_live = (state_q == TK_WALK);
    assign wr_col   = dir_q ? (LAST - idx_q) : idx_q;
endmodule

// File: rtl/sd_row_bank.sv
module sd_row_bank
    import sd_pkg::*;
#(
    parameter int NCOL = 8,
    localparam int CIDX_W = (NCOL > 1) ? $clog2(NCOL) : 1,
    localparam int ROW_W  = NCOL * PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CIDX_W-1:0] wr_col,
    input  logic [PIX_W-1:0]  pixel,
    input  logic              inv_en,
    output logic [ROW_W-1:0]  cap_row
);
    logic [PIX_W-1:0] wr_val;
    assign wr_val = pix_fix(pixel, inv_en);

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [PIX_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (wr_en && (wr_col == CIDX_W'(c))) begin
                cell_q <= wr_val;
            end
        end
        assign cap_row[c*PIX_W +: PIX_W] = cell_q;
    end
endmodule

// File: rtl/sd_row_out.sv
module sd_row_out #(
    parameter int ROW_W = 144
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch,
    input  logic             pol_in,
    input  logic [ROW_W-1:0] cap_row,
    output logic [ROW_W-1:0] row_data,
    output logic             row_pol,
    output logic             row_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            row_data  <= '0;
            row_pol   <= 1'b0;
            row_valid <= 1'b0;
        end else begin
            row_valid <= latch;
            if (latch) begin
                row_data <= cap_row;
                row_pol  <= pol_in;
            end
        end
    end
endmodule

// File: rtl/sd_source_row.sv
module sd_source_row
    import sd_pkg::*;
#(
    parameter int NCOL = 8,
    localparam int CIDX_W = (NCOL > 1) ? $clog2(NCOL) : 1,
    localparam int ROW_W  = NCOL * PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             shift,
    input  logic [PIX_W-1:0] pixel,
    input  logic             inv_en,
    input  logic             dir_rl,
    input  logic             latch,
    input  logic             pol_in,
    output logic [ROW_W-1:0] row_data,
    output logic             row_pol,
    output logic             row_valid
);
    logic              tok_live;
    logic              wr_en;
    logic [CIDX_W-1:0] wr_col;
    logic [ROW_W-1:0]  cap_row;

    sd_token_seq #(.NCOL(NCOL)) u_seq (
        .clk(clk), .rst(rst), .start(start), .shift(shift), .dir_rl(dir_rl),
        .tok_live(tok_live), .wr_en(wr_en), .wr_col(wr_col)
    );

    sd_row_bank #(.NCOL(NCOL)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_col(wr_col),
        .pixel(pixel), .inv_en(inv_en), .cap_row(cap_row)
    );

    sd_row_out #(.ROW_W(ROW_W)) u_out (
        .clk(clk), .rst(rst), .latch(latch), .pol_in(pol_in),
        .cap_row(cap_row), .row_data(row_data), .row_pol(row_pol),
        .row_valid(row_valid)
    );
endmodule

// File: rtl/sd_source_row_chk.sv
module sd_source_row_chk #(
    parameter int ROW_W = 144
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             latch,
    input logic             pol_in,
    input logic             tok_live,
    input logic [ROW_W-1:0] cap_row,
    input logic [ROW_W-1:0] row_data,
    input logic             row_pol,
    input logic             row_valid
);
    a_r2_start_arms: assert property (@(posedge clk) disable iff (rst)
        start |=> (tok_live && $stable(cap_row)));

    a_r5_idle_shift: assert property (@(posedge clk) disable iff (rst)
        (!tok_live && !start) |=> $stable(cap_row));

    a_r8_copy: assert property (@(posedge clk) disable iff (rst)
        latch |=> (row_data == $past(cap_row)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !latch |=> ($stable(row_data) && $stable(row_pol)));

    a_r9_pol: assert property (@(posedge clk) disable iff (rst)
        latch |=> (row_pol == $past(pol_in)));

    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        latch |=> row_valid);

    a_r9_valid_quiet: assert property (@(posedge clk) disable iff (rst)
        !latch |=> !row_valid);
endmodule

bind sd_source_row sd_source_row_chk #(.ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .latch(latch), .pol_in(pol_in),
    .tok_live(tok_live), .cap_row(cap_row), .row_data(row_data),
    .row_pol(row_pol), .row_valid(row_valid)
);

// File: tb/sd_source_row_tb.sv
module sd_source_row_tb;
    localparam int NCOL  = 8;
    localparam int PW    = 18;
    localparam int ROW_W = NCOL * PW;

    logic clk = 1'b0;
    logic rst, start, shift, inv_en, dir_rl, latch, pol_in;
    logic [PW-1:0]    pixel;
    logic [ROW_W-1:0] row_data;
    logic             row_pol, row_valid;

    always #4 clk = ~clk;

    sd_source_row #(.NCOL(NCOL)) u_dut (
        .clk(clk), .rst(rst), .start(start), .shift(shift), .pixel(pixel),
        .inv_en(inv_en), .dir_rl(dir_rl), .latch(latch), .pol_in(pol_in),
        .row_data(row_data), .row_pol(row_pol), .row_valid(row_valid)
    );

    // behavioural reference
    logic [PW-1:0] m_cap [NCOL];
    logic [PW-1:0] m_out [NCOL];
    logic m_pol, m_val, m_live, m_dir;
    int   m_pos;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCOL; c++) begin
                m_cap[c] = '0;
                m_out[c] = '0;
            end
            m_pol = 0; m_val = 0; m_live = 0; m_dir = 0; m_pos = 0;
        end else begin
            m_val = latch;
            if (latch) begin
                for (int c = 0; c < NCOL; c++) m_out[c] = m_cap[c];
                m_pol = pol_in;
            end
            if (start) begin
                m_live = 1; m_pos = 0; m_dir = dir_rl;
            end else if (shift && m_live) begin
                m_cap[m_dir ? NCOL-1-m_pos : m_pos] = inv_en ? ~pixel : pixel;
                m_pos++;
                if (m_pos == NCOL) begin
                    m_live = 0; m_pos = 0;
                end
            end
        end
    end

    int    n_tests = 0, n_fail = 0;
    string tag = "R1";
    int    seed = 1;

    function automatic logic [PW-1:0] pat(int k);
        return PW'((k * 40503 + 7919) & 18'h3ffff);
    endfunction

    task automatic compare();
        logic [ROW_W-1:0] exp_row;
        for (int c = 0; c < NCOL; c++) exp_row[c*PW +: PW] = m_out[c];
        n_tests += 3;
        if (row_data !== exp_row) begin
            n_fail++;
            $display("FAIL %s row_data act=%h exp=%h", tag, row_data, exp_row);
        end
        if (row_pol !== m_pol) begin
            n_fail++;
            $display("FAIL %s row_pol act=%b exp=%b", tag, row_pol, m_pol);
        end
        if (row_valid !== m_val) begin
            n_fail++;
            $display("FAIL %s row_valid act=%b exp=%b", tag, row_valid, m_val);
        end
    endtask

    task automatic step(input logic st, input logic sh, input logic lt);
        start = st; shift = sh; latch = lt;
        pixel = pat(seed); seed++;
        @(posedge clk);
        @(negedge clk);
        compare();
        start = 0; shift = 0; latch = 0;
    endtask

    task automatic shifts(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 0);
    endtask

    task automatic do_latch(input logic p);
        pol_in = p;
        step(0, 0, 1);
        step(0, 0, 0);
    endtask

    initial begin
        rst = 1; start = 0; shift = 0; latch = 0; inv_en = 0; dir_rl = 0;
        pol_in = 1; pixel = '0;
        repeat (3) @(negedge clk);
        // R1: outputs clear while in reset, with strobes being ignored
        start = 1; shift = 1; latch = 1;
        @(negedge clk);
        compare();
        n_tests++;
        if (row_data !== '0 || row_pol !== 0 || row_valid !== 0) begin
            n_fail++;
            $display("FAIL R1 reset state act=%h/%b/%b exp=0/0/0", row_data, row_pol, row_valid);
        end
        rst = 0; start = 0; shift = 0; latch = 0;

        tag = "R3"; dir_rl = 0;           // left-to-right full row
        step(1, 0, 0); shifts(NCOL); do_latch(1);
        tag = "R3"; dir_rl = 1;           // right-to-left full row
        step(1, 0, 0); shifts(NCOL); do_latch(0);
        tag = "R7"; inv_en = 1; dir_rl = 0;
        step(1, 0, 0); shifts(NCOL); inv_en = 0; do_latch(1);
        tag = "R4";                        // shifts past the last column
        step(1, 0, 0); shifts(NCOL + 4); do_latch(0);
        tag = "R5";                        // partial row, idle shifts
        dir_rl = 1; step(1, 0, 0); shifts(3);
        step(1, 0, 0); shifts(NCOL); shifts(5); do_latch(1);
        dir_rl = 0; step(1, 0, 0); shifts(2); do_latch(0);
        tag = "R6";                        // restart mid row
        step(1, 0, 0); shifts(4); step(1, 0, 0); shifts(3); do_latch(1);
        tag = "R2";                        // start and shift together
        step(1, 1, 0); shifts(2); step(1, 1, 0); shifts(NCOL); do_latch(0);
        tag = "R10";                       // direction changes mid row
        dir_rl = 1; step(1, 0, 0); shifts(2); dir_rl = 0; shifts(3);
        dir_rl = 1; shifts(3); do_latch(1);
        tag = "R8";                        // latch in the same cycle as a write
        dir_rl = 0; step(1, 0, 0); shifts(3);
        pol_in = 0; step(0, 1, 1); step(0, 1, 1); shifts(2); do_latch(1);
        tag = "R9";                        // back-to-back latches, alternating polarity
        for (int i = 0; i < 6; i++) begin
            pol_in = i[0];
            step(0, 0, 1);
        end
        step(0, 0, 0); step(0, 0, 0);
        tag = "R1";                        // reset in mid row clears everything
        step(1, 0, 0); shifts(3);
        rst = 1; step(0, 1, 0); rst = 0; do_latch(1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule